// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits in front of a processor's program sequencer and decides which interrupt, if any, is offered next. It collects twelve request levels: a reset request, a nonmaskable power-down request, six external pins and a set of internal pulse requests from the timer, byte DMA, two serial ports and software forces. From these it offers the most urgent request that is pending, unmasked and permitted, together with that level's fixed vector address.

The sequencer accepts an offer by pulsing `ack`. This clears the level's sticky latch and marks the level as in service. Pulsing `rti` retires the most urgent in-service level. Software reaches the block through three write strobes: a mask word, a control word (sense options and nesting), and a force/clear pair. Two pulses turn interrupt servicing off and on globally.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Level k (0 is most urgent) carries a fixed vector. Level 0 is the reset request at 0x0000 and level 1 is power-down at 0x002C. Every level k from 2 to 11 uses (k-1)*4: pin 0 at 2, pin 1 at 3, pin 2 at 4, serial-0 transmit at 5, serial-0 receive at 6, pin 3 at 7, byte DMA at 8, serial-1 transmit or pin 4 at 9, serial-1 receive or pin 5 at 10, and timer at 11. The lowest-numbered eligible level is offered on `irq_level`/`irq_vector` with `irq_valid` high. While `rst_req` is high, level 0 is offered whatever else holds.
- R2: Mask bit k gates level k (1 = enabled) for levels 2 to 11. Levels 0 and 1 ignore the mask.
- R3: A mask write blocks every level except 0 during the one cycle that follows the write edge.
- R4: `gie_clr` disables offering of every level except 0, power-down included. `gie_set` re-enables it. If both arrive together, the disable wins.
- R5: Each pin (active low) passes through a SYNC_STAGES-flop synchronizer. With the default of 2 stages, a level-sensed pin is offered after the second clock edge following its fall and withdrawn two edges after it rises. Pins 1 and 2 (levels 3, 4) are always level-sensed.
- R6: In edge mode, a falling edge on a pin sets a sticky latch that is offered after the third edge and stays pending after the pin rises. Pin 3 (level 7) is always edge-sensed.
- R7: Control bit 0 makes pin 0 (level 2) edge-sensed, bit 1 does the same for pin 4 (level 9), and bit 2 for pin 5 (level 10). With the bit at 0 the pin is level-sensed, and a short low pulse leaves nothing pending.
- R8: A force/clear write sets (`fc_force`) or clears (`fc_clear`) the latches of levels 1 to 11, taking effect at that edge. When both are set for one bit, clear wins.
- R9: `ack` while an offer is valid clears that level's latch and marks it in service. `rti` retires the lowest-numbered in-service level.
- R10: With control bit 3 at 0 (sequential), nothing except level 0 is offered while any level is in service.
- R11: With control bit 3 at 1 (nesting), only levels more urgent than the most urgent in-service level are offered.
- R12: After reset, the mask, control word and all latches are zero, servicing is enabled and nothing is offered.
- R13: Pulses on `pwrdn_req` and `int_req` set their latches at the edge they are sampled. `int_req` bits 0 to 5 map to levels 5, 6, 8, 9, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_req | input | 1 | Reset interrupt request, level 0 |
| pin_n | input | 6 | External interrupt pins, active low |
| pwrdn_req | input | 1 | Power-down request pulse, level 1 |
| int_req | input | 6 | Internal request pulses |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 12 | Mask value, bit k enables level k |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Sense bits 2:0, nesting bit 3 |
| fc_we | input | 1 | Force/clear write strobe |
| fc_force | input | 12 | Latch set bits |
| fc_clear | input | 12 | Latch clear bits |
| gie_set | input | 1 | Global enable pulse |
| gie_clr | input | 1 | Global disable pulse |
| ack | input | 1 | Sequencer accepts the current offer |
| rti | input | 1 | Sequencer returns from the most urgent in-service level |
| irq_valid | output | 1 | An offer is present |
| irq_level | output | 4 | Offered level |
| irq_vector | output | VEC_W | Vector address of the offered level |

## Verification
The output selection is combinational, so a faulty latch, mask, enable or in-service bit changes `irq_valid`, `irq_level` or `irq_vector` in the same cycle the state goes wrong. The bench samples these outputs one cycle after every stimulus edge. A lost or stuck latch shows up either as a missing offer or as an offer that survives a clear or an acknowledge. A wrong in-service record shows up as an offer that should be held back in sequential or nesting mode, or as one that is wrongly held back, seen right after the relevant `ack` or `rti`. Synchronizer depth errors move the first valid cycle after a pin edge by one or more clocks, and the bench checks the cycle before and the cycle of the expected change.

// File: rtl/irqvc_pkg.sv
package irqvc_pkg;
   localparam int NLVL  = 12;
   localparam int LVL_W = $clog2(NLVL);
   localparam int NPIN  = 6;
   localparam int NINT  = 6;

   localparam logic [NLVL-1:0] UNMASKABLE = 12'b0000_0000_0011;
   localparam logic [NLVL-1:0] RESET_ONLY = 12'b0000_0000_0001;
   localparam logic [NLVL-1:0] LATCH_EN   = 12'b1111_1111_1110;

   typedef struct packed {
      logic nest;
      logic sense_l10;
      logic sense_l9;
      logic sense_l2;
   } ctl_t;

   function automatic logic [15:0] lvl_vector(input logic [LVL_W-1:0] idx);
      logic [15:0] v;
      if (idx == '0)
         v = 16'h0000;
      else if (idx == LVL_W'(1))
         v = 16'h002C;
      else
         v = (16'(idx) - 16'd1) << 2;
      return v;
   endfunction
endpackage

// File: rtl/irqvc_pin_sync.sv
module irqvc_pin_sync
   import irqvc_pkg::*;
#(
   parameter int N      = NPIN,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_n,
   output logic [N-1:0] lvl_act,
   output logic [N-1:0] fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqvc_pin_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_pin
      logic [STAGES:0] sh;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[STAGES-1:0], pin_n[i]};
      end

      assign lvl_act[i] = ~sh[STAGES-1];
      assign fall[i]    = sh[STAGES] & ~sh[STAGES-1];

      // R6: an edge is reported for a single cycle only
      a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
         fall[i] |=> !fall[i]);
   end
endmodule

// File: rtl/irqvc_latch_bank.sv
module irqvc_latch_bank
   import irqvc_pkg::*;
#(
   parameter logic [NLVL-1:0] EN = LATCH_EN
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NLVL-1:0]  set_evt,
   input  logic             ack_ok,
   input  logic [LVL_W-1:0] ack_lvl,
   input  logic             fc_we,
   input  logic [NLVL-1:0]  fc_force,
   input  logic [NLVL-1:0]  fc_clear,
   output logic [NLVL-1:0]  latch
);
   for (genvar k = 0; k < NLVL; k++) begin : g_bit
      if (EN[k]) begin : g_on
         logic q, nxt;

         always_comb begin
            nxt = q;
            if (ack_ok && ack_lvl == LVL_W'(k)) nxt = 1'b0;
            if (set_evt[k])                     nxt = 1'b1;
            if (fc_we && fc_force[k])           nxt = 1'b1;
            if (fc_we && fc_clear[k])           nxt = 1'b0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= nxt;
         end

         assign latch[k] = q;

         a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            fc_we && fc_clear[k] |=> !latch[k]);
         a_r13_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[k] && !(fc_we && fc_clear[k]) |=> latch[k]);
         a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ack_ok && ack_lvl == LVL_W'(k) && !set_evt[k] && !(fc_we && fc_force[k])
            |=> !latch[k]);
      end else begin : g_off
         assign latch[k] = 1'b0;
      end
   end
endmodule

// File: rtl/irqvc_service.sv
module irqvc_service
   import irqvc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_ok,
   input  logic [LVL_W-1:0] ack_lvl,
   input  logic             rti,
   output logic [NLVL-1:0]  isr
);
   logic [NLVL-1:0] isr_n;
   logic            found;

   always_comb begin
      isr_n = isr;
      found = 1'b0;
      if (rti) begin
         for (int k = 0; k < NLVL; k++) begin
            if (!found && isr[k]) begin
               isr_n[k] = 1'b0;
               found    = 1'b1;
            end
         end
      end
      if (ack_ok) begin
         for (int k = 0; k < NLVL; k++)
            if (ack_lvl == LVL_W'(k)) isr_n[k] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr <= '0;
      else        isr <= isr_n;
   end

   // R9: a return without a new acknowledge retires exactly one level
   a_r9_rti_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
      rti && !ack_ok && isr != '0 |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

// File: rtl/irqvc_select.sv
module irqvc_select
   import irqvc_pkg::*;
#(
   parameter int VEC_W = 14
)(
   input  logic [NLVL-1:0]  pending,
   input  logic [NLVL-1:0]  mask,
   input  logic [NLVL-1:0]  isr,
   input  logic             gen_en,
   input  logic             blackout,
   input  logic             nest,
   output logic             valid,
   output logic [LVL_W-1:0] lvl,
   output logic [VEC_W-1:0] vector
);
   logic [NLVL-1:0] cand;
   int              hi;

   always_comb begin
      cand = pending & (mask | UNMASKABLE);
      if (!gen_en || blackout) cand = cand & RESET_ONLY;

      hi = NLVL;
      for (int k = NLVL - 1; k >= 0; k--)
         if (isr[k]) hi = k;

      if (hi != NLVL) begin
         if (nest) begin
            for (int k = 1; k < NLVL; k++)
               if (k >= hi) cand[k] = 1'b0;
         end else begin
            cand = cand & RESET_ONLY;
         end
      end

      valid = |cand;
      lvl   = '0;
      for (int k = NLVL - 1; k >= 0; k--)
         if (cand[k]) lvl = LVL_W'(k);
   end

   assign vector = VEC_W'(lvl_vector(lvl));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqvc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 14
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req,
   input  logic [NPIN-1:0]   pin_n,
   input  logic              pwrdn_req,
   input  logic [NINT-1:0]   int_req,
   input  logic              mask_we,
   input  logic [NLVL-1:0]   mask_wdata,
   input  logic              ctl_we,
   input  logic [3:0]        ctl_wdata,
   input  logic              fc_we,
   input  logic [NLVL-1:0]   fc_force,
   input  logic [NLVL-1:0]   fc_clear,
   input  logic              gie_set,
   input  logic              gie_clr,
   input  logic              ack,
   input  logic              rti,
   output logic              irq_valid,
   output logic [LVL_W-1:0]  irq_level,
   output logic [VEC_W-1:0]  irq_vector
);
   if (VEC_W < 6 || VEC_W > 16) begin : g_bad_vec
      $error("irq_vector_ctrl: VEC_W must lie in 6..16");
   end

   logic [NLVL-1:0] mask_q;
   ctl_t            ctl_q;
   logic            blackout_q;
   logic            gen_en_q;
   logic [NPIN-1:0] lvl_act, fall;
   logic [NLVL-1:0] set_evt, lvl_src, latch, pending, isr;
   logic            ack_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '0;
         ctl_q      <= '0;
         blackout_q <= 1'b0;
         gen_en_q   <= 1'b1;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         if (ctl_we)  ctl_q  <= ctl_t'(ctl_wdata);
         blackout_q <= mask_we;
         if (gie_clr)      gen_en_q <= 1'b0;
         else if (gie_set) gen_en_q <= 1'b1;
      end
   end

   irqvc_pin_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .lvl_act(lvl_act), .fall(fall));

   always_comb begin
      set_evt     = '0;
      set_evt[1]  = pwrdn_req;
      set_evt[2]  = ctl_q.sense_l2 & fall[0];
      set_evt[5]  = int_req[0];
      set_evt[6]  = int_req[1];
      set_evt[7]  = fall[3];
      set_evt[8]  = int_req[2];
      set_evt[9]  = int_req[3] | (ctl_q.sense_l9 & fall[4]);
      set_evt[10] = int_req[4] | (ctl_q.sense_l10 & fall[5]);
      set_evt[11] = int_req[5];

      lvl_src     = '0;
      lvl_src[0]  = rst_req;
      lvl_src[2]  = ~ctl_q.sense_l2 & lvl_act[0];
      lvl_src[3]  = lvl_act[1];
      lvl_src[4]  = lvl_act[2];
      lvl_src[9]  = ~ctl_q.sense_l9 & lvl_act[4];
      lvl_src[10] = ~ctl_q.sense_l10 & lvl_act[5];
   end

   assign ack_ok = ack & irq_valid;

   irqvc_latch_bank #(.EN(LATCH_EN)) u_latch (
      .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .ack_ok(ack_ok),
      .ack_lvl(irq_level), .fc_we(fc_we), .fc_force(fc_force),
      .fc_clear(fc_clear), .latch(latch));

   assign pending = latch | lvl_src;

   irqvc_service u_svc (
      .clk(clk), .rst_n(rst_n), .ack_ok(ack_ok), .ack_lvl(irq_level),
      .rti(rti), .isr(isr));

   irqvc_select #(.VEC_W(VEC_W)) u_sel (
      .pending(pending), .mask(mask_q), .isr(isr), .gen_en(gen_en_q),
      .blackout(blackout_q), .nest(ctl_q.nest), .valid(irq_valid),
      .lvl(irq_level), .vector(irq_vector));

   a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> irq_valid && irq_level == '0);
   a_r1_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_vector[1:0] == 2'b00);
   a_r2_mask_honoured: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && irq_level >= LVL_W'(2) |-> mask_q[irq_level]);
   a_r3_blackout: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> !irq_valid || irq_level == '0);
   a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr |=> !irq_valid || irq_level == '0);
   a_r10_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && !ctl_q.nest && irq_level != '0 |-> isr == '0);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 1'b0;
   logic [5:0]  pin_n = '1;
   logic        pwrdn_req = 1'b0;
   logic [5:0]  int_req = '0;
   logic        mask_we = 1'b0;
   logic [11:0] mask_wdata = '0;
   logic        ctl_we = 1'b0;
   logic [3:0]  ctl_wdata = '0;
   logic        fc_we = 1'b0;
   logic [11:0] fc_force = '0;
   logic [11:0] fc_clear = '0;
   logic        gie_set = 1'b0;
   logic        gie_clr = 1'b0;
   logic        ack = 1'b0;
   logic        rti = 1'b0;
   logic        irq_valid;
   logic [3:0]  irq_level;
   logic [VW-1:0] irq_vector;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_ctrl #(.SYNC_STAGES(2), .VEC_W(VW)) dut (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .pin_n(pin_n),
      .pwrdn_req(pwrdn_req), .int_req(int_req), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .fc_we(fc_we), .fc_force(fc_force), .fc_clear(fc_clear),
      .gie_set(gie_set), .gie_clr(gie_clr), .ack(ack), .rti(rti),
      .irq_valid(irq_valid), .irq_level(irq_level), .irq_vector(irq_vector));

   // table row: mask[23:12] pd[11] int[10:5] exp_valid[4] exp_level[3:0]
   localparam int NV = 8;
   localparam logic [23:0] TBL [NV] = '{
      {12'hFFF, 1'b0, 6'b111111, 1'b1, 4'd5},
      {12'hFFF, 1'b0, 6'b100000, 1'b1, 4'd11},
      {12'hFDF, 1'b0, 6'b000011, 1'b1, 4'd6},
      {12'h000, 1'b0, 6'b111111, 1'b0, 4'd0},
      {12'h000, 1'b1, 6'b000000, 1'b1, 4'd1},
      {12'hFFF, 1'b0, 6'b001100, 1'b1, 4'd8},
      {12'hEFF, 1'b0, 6'b001100, 1'b1, 4'd9},
      {12'hFFF, 1'b0, 6'b010000, 1'b1, 4'd10}
   };

   function automatic logic [31:0] exp_vec(input int k);
      if (k == 0) return 32'h0;
      if (k == 1) return 32'h2C;
      return 32'((k - 1) * 4);
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_offer(input string tag, input int k);
      chk({tag, " valid"}, 32'(irq_valid), 32'd1);
      chk({tag, " level"}, 32'(irq_level), 32'(k));
      chk({tag, " vector"}, 32'(irq_vector), exp_vec(k));
   endtask

   task automatic clear_all();
      fc_we = 1'b1; fc_clear = '1; step(); fc_we = 1'b0; fc_clear = '0;
   endtask

   task automatic force_lvl(input int k);
      fc_we = 1'b1; fc_force = 12'(1) << k; step(); fc_we = 1'b0; fc_force = '0;
   endtask

   task automatic wr_mask(input logic [11:0] m);
      mask_we = 1'b1; mask_wdata = m; step(); mask_we = 1'b0;
   endtask

   task automatic wr_ctl(input logic [3:0] c);
      ctl_we = 1'b1; ctl_wdata = c; step(); ctl_we = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1; step(); ack = 1'b0;
   endtask

   task automatic pulse_rti();
      rti = 1'b1; step(); rti = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R12: watchdog expired, actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R12: reset state
      chk("R12 reset no offer", 32'(irq_valid), 32'd0);
      force_lvl(5);
      chk("R12 mask resets to zero", 32'(irq_valid), 32'd0);
      clear_all();

      // R1 R2 R13: vector table
      for (int i = 0; i < NV; i++) begin
         wr_mask(TBL[i][23:12]);
         clear_all();
         pwrdn_req = TBL[i][11];
         int_req   = TBL[i][10:5];
         step();
         pwrdn_req = 1'b0;
         int_req   = '0;
         if (TBL[i][4]) chk_offer($sformatf("R1 R2 R13 row %0d", i), int'(TBL[i][3:0]));
         else chk($sformatf("R2 row %0d all masked", i), 32'(irq_valid), 32'd0);
      end
      clear_all();
      wr_mask(12'hFFF);

      // R3: one blocked cycle after a mask write
      force_lvl(5);
      chk_offer("R3 before write", 5);
      wr_mask(12'hFFF);
      chk("R3 blocked cycle", 32'(irq_valid), 32'd0);
      step();
      chk_offer("R3 after block", 5);

      // R4: global disable, reset request still wins
      gie_clr = 1'b1; step(); gie_clr = 1'b0;
      chk("R4 disabled", 32'(irq_valid), 32'd0);
      force_lvl(1);
      chk("R4 power-down blocked too", 32'(irq_valid), 32'd0);
      rst_req = 1'b1; step();
      chk_offer("R1 R4 reset request", 0);
      rst_req = 1'b0;
      gie_set = 1'b1; step(); gie_set = 1'b0;
      chk_offer("R4 re-enabled", 1);
      clear_all();

      // R5: level pin (level 3)
      pin_n[1] = 1'b0; step();
      chk("R5 first edge not yet", 32'(irq_valid), 32'd0);
      step();
      chk_offer("R5 level pin", 3);
      pin_n[1] = 1'b1; step(); step();
      chk("R5 level released", 32'(irq_valid), 32'd0);

      // R6: edge pin (level 7), sticky, cleared by ack (R9)
      pin_n[3] = 1'b0; step(); step();
      chk("R6 not before third edge", 32'(irq_valid), 32'd0);
      step();
      chk_offer("R6 edge latched", 7);
      pin_n[3] = 1'b1; step(); step(); step();
      chk_offer("R6 sticky after rise", 7);
      pulse_ack();
      chk("R9 R10 acked", 32'(irq_valid), 32'd0);
      pulse_rti();
      chk("R9 latch cleared by ack", 32'(irq_valid), 32'd0);

      // R7: pin 0 in edge mode, then in level mode
      wr_ctl(4'b0001);
      pin_n[0] = 1'b0; step(); pin_n[0] = 1'b1; step(); step();
      chk_offer("R7 pin0 edge mode", 2);
      fc_we = 1'b1; fc_clear = 12'h004; step(); fc_we = 1'b0; fc_clear = '0;
      chk("R8 clear latch", 32'(irq_valid), 32'd0);
      wr_ctl(4'b0000);
      pin_n[0] = 1'b0; step(); pin_n[0] = 1'b1; step();
      chk_offer("R5 R7 short pulse seen", 2);
      step(); step();
      chk("R7 level mode not sticky", 32'(irq_valid), 32'd0);
      wr_ctl(4'b0010);
      pin_n[4] = 1'b0; step(); pin_n[4] = 1'b1; step(); step();
      chk_offer("R7 pin4 edge mode", 9);
      clear_all();
      wr_ctl(4'b0000);

      // R8: force, and clear winning over force
      force_lvl(7);
      chk_offer("R8 forced", 7);
      fc_we = 1'b1; fc_force = 12'h080; fc_clear = 12'h080; step();
      fc_we = 1'b0; fc_force = '0; fc_clear = '0;
      chk("R8 clear wins", 32'(irq_valid), 32'd0);

      // R10 R11: sequential then nesting
      force_lvl(11);
      chk_offer("R10 timer offered", 11);
      pulse_ack();
      force_lvl(5);
      chk("R10 held while in service", 32'(irq_valid), 32'd0);
      wr_ctl(4'b1000);
      chk_offer("R11 more urgent preempts", 5);
      pulse_ack();
      force_lvl(6);
      chk("R11 less urgent held", 32'(irq_valid), 32'd0);
      pulse_rti();
      chk_offer("R9 R11 after retire", 6);
      pulse_ack();
      pulse_rti();
      pulse_rti();
      chk("R9 all retired", 32'(irq_valid), 32'd0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule